// File: doc/BRIEF.md
# Window Threshold Trip Interrupt Unit

This block watches a stream of channel samples and flags every sample that leaves the window set for its channel. Each sample carries a channel index. It is compared against a low and a high threshold for that channel, and both thresholds arrive as flat input vectors. A sample below its low bound sets a sticky bit in the low-trip flag register. A sample above its high bound sets a sticky bit in the high-trip flag register. The bit position in both registers is the channel index.

Software reaches four 16-bit registers through a plain register port: the two flag registers and one enable mask for each. The single interrupt output is registered. It is the OR of every flag bit whose matching enable bit is set. Software clears flags by writing them. It can also write a flag bit to 1 to raise the interrupt deliberately.

The sample input is a valid/ready stream. The unit takes one sample in every cycle and never applies back-pressure: ready is high in every cycle after reset is released. A sample counts as transferred in a cycle when valid and ready are both high. While valid is low, the sample and channel inputs are ignored.

Top module: `wtrip_irq_unit`

## Requirements
- R1: A transferred sample on channel n that is strictly less than that channel's low threshold sets bit n of the low-trip flag register (address 4'h2) at the next clock edge. A sample equal to the threshold sets nothing.
- R2: A transferred sample on channel n that is strictly greater than that channel's high threshold sets bit n of the high-trip flag register (address 4'h3) at the next clock edge. A sample equal to the threshold sets nothing.
- R3: A flag bit that is set stays set until a software write to its register clears it.
- R4: A write to a flag register replaces its contents with the write data. Writing a 1 to a bit sets that flag.
- R5: If a hardware trip and a software write hit the same flag bit in the same cycle, the bit ends up set.
- R6: irq equals, one clock later, the OR over all bits of (low flags AND low enables) OR (high flags AND high enables).
- R7: A flag bit whose enable bit is 0 does not drive irq. The low enable mask is at address 4'h8 and the high enable mask is at 4'h9.
- R8: After reset, all four registers read 0x0000 and irq is 0.
- R9: A read of any address other than 4'h2, 4'h3, 4'h8 or 4'h9 returns 0x0000. A write to such an address changes no register. Reads are combinational from reg_addr.
- R10: smp_ready is 1 whenever reset is not asserted. While smp_valid is 0, no flag is set, whatever smp_data and smp_chan hold.
- R11: Channel n uses its low threshold from lo_thr_flat[16n+15:16n] and its high threshold from hi_thr_flat[16n+15:16n]. A trip sets only bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, high when out of reset |
| smp_chan | input | 4 | Channel index of the sample |
| smp_data | input | 16 | Unsigned sample value |
| lo_thr_flat | input | 256 | Low thresholds, 16 bits per channel |
| hi_thr_flat | input | 256 | High thresholds, 16 bits per channel |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Every channel receives samples one below, equal to, and one above each of its thresholds, along with a value inside the window. A design that used a non-strict compare would trip at equality. One that indexed thresholds wrongly would set flags at the wrong distances or at the wrong bit. A same-cycle clearing write and hardware trip check that the trip is not lost. Every unmapped address is written with all ones, then read. Walking single flags against matching and complementary enable masks exposes an interrupt that ignores the mask, mixes up the two flag sets, or responds with the wrong latency.

// File: rtl/wtrip_pkg.sv
package wtrip_pkg;
  localparam int REG_W       = 16;
  localparam int ADDR_LO_FLG = 'h2;
  localparam int ADDR_HI_FLG = 'h3;
  localparam int ADDR_LO_EN  = 'h8;
  localparam int ADDR_HI_EN  = 'h9;
endpackage

// File: rtl/wtrip_compare.sv
module wtrip_compare #(
  parameter int NCH = 16,
  parameter int DW  = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CW-1:0]     chan,
  input  logic [DW-1:0]     data,
  input  logic [NCH*DW-1:0] lo_thr,
  input  logic [NCH*DW-1:0] hi_thr,
  output logic [NCH-1:0]    lo_hit,
  output logic [NCH-1:0]    hi_hit
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel       = take && (chan == CW'(n));
    assign lo_hit[n] = sel && (data < lo_thr[n*DW +: DW]);
    assign hi_hit[n] = sel && (data > hi_thr[n*DW +: DW]);
  end

  // R11: at most one channel trips per sample
  assert_single_chan_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lo_hit | hi_hit));
endmodule

// File: rtl/wtrip_flagreg.sv
module wtrip_flagreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (wr_en ? wr_data : q) | set_i;
  end

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((q & $past(q)) == $past(q)));

  assert_hw_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/wtrip_irq_unit.sv
module wtrip_irq_unit #(
  parameter int NCH = 16,
  parameter int DW  = 16,
  parameter int AW  = 4,
  localparam int CW = $clog2(NCH),
  localparam int RW = wtrip_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CW-1:0]     smp_chan,
  input  logic [DW-1:0]     smp_data,
  input  logic [NCH*DW-1:0] lo_thr_flat,
  input  logic [NCH*DW-1:0] hi_thr_flat,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_we,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  output logic              irq
);
  import wtrip_pkg::*;

  logic [NCH-1:0] lo_hit, hi_hit, lo_q, hi_q;
  logic [NCH-1:0] lo_en, hi_en;
  logic sel_lf, sel_hf, sel_le, sel_he;

  assign smp_ready = rst_n;

  assign sel_lf = reg_addr == AW'(ADDR_LO_FLG);
  assign sel_hf = reg_addr == AW'(ADDR_HI_FLG);
  assign sel_le = reg_addr == AW'(ADDR_LO_EN);
  assign sel_he = reg_addr == AW'(ADDR_HI_EN);

  wtrip_compare #(.NCH(NCH), .DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .take(smp_valid && smp_ready), .chan(smp_chan), .data(smp_data),
    .lo_thr(lo_thr_flat), .hi_thr(hi_thr_flat),
    .lo_hit(lo_hit), .hi_hit(hi_hit));

  wtrip_flagreg #(.W(NCH)) u_lo_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we && sel_lf),
    .wr_data(reg_wdata[NCH-1:0]), .set_i(lo_hit), .q(lo_q));

  wtrip_flagreg #(.W(NCH)) u_hi_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we && sel_hf),
    .wr_data(reg_wdata[NCH-1:0]), .set_i(hi_hit), .q(hi_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_en <= '0;
      hi_en <= '0;
      irq   <= 1'b0;
    end else begin
      if (reg_we && sel_le) lo_en <= reg_wdata[NCH-1:0];
      if (reg_we && sel_he) hi_en <= reg_wdata[NCH-1:0];
      irq <= |((lo_q & lo_en) | (hi_q & hi_en));
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_lf) reg_rdata[NCH-1:0] = lo_q;
    if (sel_hf) reg_rdata[NCH-1:0] = hi_q;
    if (sel_le) reg_rdata[NCH-1:0] = lo_en;
    if (sel_he) reg_rdata[NCH-1:0] = hi_en;
  end

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |(($past(lo_q) & $past(lo_en)) | ($past(hi_q) & $past(hi_en)))));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_lf || sel_hf || sel_le || sel_he) |-> (reg_rdata == '0));
endmodule

// File: tb/wtrip_irq_unit_bench.sv
module wtrip_irq_unit_bench;
  localparam int NCH = 16;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [3:0] smp_chan = '0;
  logic [15:0] smp_data = '0;
  logic [NCH*DW-1:0] lo_thr_flat, hi_thr_flat;
  logic [3:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] mlf = '0, mhf = '0, mle = '0, mhe = '0;

  always #2 clk = ~clk;

  wtrip_irq_unit u_wtrip_irq_unit (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_chan(smp_chan), .smp_data(smp_data),
    .lo_thr_flat(lo_thr_flat), .hi_thr_flat(hi_thr_flat),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [15:0] lo_of(int n); return 16'(100 + 10*n); endfunction
  function automatic logic [15:0] hi_of(int n); return 16'(400 + 20*n); endfunction

  initial begin
    for (int n = 0; n < NCH; n++) begin
      lo_thr_flat[n*DW +: DW] = lo_of(n);
      hi_thr_flat[n*DW +: DW] = hi_of(n);
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(int ch, logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = 4'(ch); smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
    if (d < lo_of(ch)) mlf[ch] = 1'b1;
    if (d > hi_of(ch)) mhf[ch] = 1'b1;
  endtask

  task automatic irq_chk(string req);
    logic e;
    @(negedge clk); @(negedge clk);
    e = |((mlf & mle) | (mhf & mhe));
    chk(req, {15'd0, irq}, {15'd0, e});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] vals [5];
    repeat (3) @(negedge clk);
    // R8: reset values
    chk("R8 irq in reset", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    foreach (vals[i]) vals[i] = '0;
    rd(4'h2, v); chk("R8 low flags", v, 16'h0);
    rd(4'h3, v); chk("R8 high flags", v, 16'h0);
    rd(4'h8, v); chk("R8 low en", v, 16'h0);
    rd(4'h9, v); chk("R8 high en", v, 16'h0);
    chk("R10 ready", {15'd0, smp_ready}, 16'd1);

    // R10: valid low, tripping data ignored
    @(negedge clk);
    smp_chan = 4'd5; smp_data = 16'd0;
    repeat (2) @(negedge clk);
    smp_data = 16'hFFFF;
    repeat (2) @(negedge clk);
    rd(4'h2, v); chk("R10 low flags idle", v, 16'h0);
    rd(4'h3, v); chk("R10 high flags idle", v, 16'h0);

    // R1 R2 R3 R11: per-channel sweep around thresholds, flags accumulate
    for (int ch = 0; ch < NCH; ch++) begin
      vals[0] = lo_of(ch) - 16'd1; vals[1] = lo_of(ch);
      vals[2] = hi_of(ch);         vals[3] = hi_of(ch) + 16'd1;
      vals[4] = 16'(250);
      for (int k = 0; k < 5; k++) begin
        send(ch, vals[(k + ch) % 5]);
        rd(4'h2, v); chk("R1 R3 R11 low flags", v, mlf);
        rd(4'h3, v); chk("R2 R3 R11 high flags", v, mhf);
      end
    end

    // R4: clear and force by writes
    wr(4'h2, 16'h0000); mlf = '0;
    wr(4'h3, 16'h0000); mhf = '0;
    rd(4'h2, v); chk("R4 low clear", v, 16'h0);
    rd(4'h3, v); chk("R4 high clear", v, 16'h0);
    wr(4'h2, 16'hA5C3); mlf = 16'hA5C3;
    rd(4'h2, v); chk("R4 low force", v, 16'hA5C3);
    wr(4'h2, 16'h0000); mlf = '0;

    // R5: same-cycle clearing write and trip on channel 3
    @(negedge clk);
    reg_addr = 4'h2; reg_wdata = 16'h0000; reg_we = 1'b1;
    smp_valid = 1'b1; smp_chan = 4'd3; smp_data = 16'd0;
    @(negedge clk);
    reg_we = 1'b0; smp_valid = 1'b0;
    mlf = 16'h0008;
    rd(4'h2, v); chk("R5 hw set wins", v, 16'h0008);
    wr(4'h2, 16'h0000); mlf = '0;

    // R6 R7: walking flags against enable masks
    for (int i = 0; i < NCH; i++) begin
      wr(4'h2, 16'(1 << i)); mlf = 16'(1 << i);
      wr(4'h8, ~16'(1 << i)); mle = ~16'(1 << i);
      irq_chk("R7 low masked");
      wr(4'h8, 16'(1 << i)); mle = 16'(1 << i);
      irq_chk("R6 low enabled");
      wr(4'h2, 16'h0); mlf = '0;
      wr(4'h8, 16'h0); mle = '0;
      wr(4'h3, 16'(1 << i)); mhf = 16'(1 << i);
      wr(4'h9, ~16'(1 << i)); mhe = ~16'(1 << i);
      irq_chk("R7 high masked");
      wr(4'h8, 16'(1 << i)); mle = 16'(1 << i);
      irq_chk("R7 low en does not pass high flag");
      wr(4'h9, 16'hFFFF); mhe = 16'hFFFF;
      irq_chk("R6 high enabled");
      wr(4'h3, 16'h0); mhf = '0;
      wr(4'h8, 16'h0); mle = '0;
      wr(4'h9, 16'h0); mhe = '0;
    end
    // R6: one-cycle latency of irq after write
    wr(4'h9, 16'h0001); mhe = 16'h0001;
    @(negedge clk);
    reg_addr = 4'h3; reg_wdata = 16'h0001; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R6 irq not yet", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R6 irq one clock later", {15'd0, irq}, 16'd1);
    mhf = 16'h0001;

    // R9: unmapped addresses
    wr(4'h8, 16'h1234); mle = 16'h1234;
    for (int a = 0; a < 16; a++) begin
      if (a == 2 || a == 3 || a == 8 || a == 9) continue;
      wr(4'(a), 16'hFFFF);
      rd(4'(a), v); chk("R9 unmapped read", v, 16'h0);
    end
    rd(4'h2, v); chk("R9 low flags kept", v, mlf);
    rd(4'h3, v); chk("R9 high flags kept", v, mhf);
    rd(4'h8, v); chk("R9 low en kept", v, mle);
    rd(4'h9, v); chk("R9 high en kept", v, mhe);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule